// File: doc/BRIEF.md
# Banked UART Register Front End

This block is the bus-side register file of a 16550-style UART. One small address space carries several registers. A divisor-latch access bit in the line control register selects what offsets 0 and 4 reach. With the bit clear, offset 0 is the data port: a read takes the oldest byte from a 16-entry receive FIFO, and a write adds a byte to a 16-entry transmit FIFO. With the bit set, offsets 0 and 4 reach the low and high bytes of a 16-bit baud divisor.

The serial shifters sit outside the block. A receive shifter pushes each character into the receive FIFO, together with its parity-error, framing-error and break flags. A transmit shifter takes bytes from the head of the transmit FIFO whenever it reports that it is idle. The block also divides its clock by the divisor to produce the 16x oversampling tick, which is one cycle wide. It reports line status for the byte that the next data read will return, so software reads status first and data second.

Top module: `uart_regbank`

## Requirements
- R1: With the access bit (line control bit 7) at 0, a read at offset 0x00 returns the oldest receive byte and removes it, and a write at offset 0x00 appends the byte to the transmit FIFO.
- R2: With the access bit at 1, offset 0x00 reads and writes divisor bits 7:0 and offset 0x04 reads and writes divisor bits 15:8. Neither FIFO is touched by these accesses.
- R3: The line control register sits at offset 0x0C, resets to 0x00 and reads back as written. Bits 1:0 give the word length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8.
- R4: `baud_tick` is high for one cycle out of every N cycles, where N is the divisor value. A divisor of 0x0000 gives N = 1, the same as 0x0001.
- R5: A write to either divisor byte restarts the tick count. The first tick comes in the N-th cycle after the write edge.
- R6: Receive data bits above the word length in force when the byte is pushed read as zero. Bit 0 is the first received bit.
- R7: The line status register at offset 0x14 holds these bits: bit 0 is data-ready (receive FIFO not empty), bit 5 is transmit-empty, and bits 2, 3 and 4 are the parity, framing and break flags of the receive FIFO head. Bits 2, 3 and 4 are 0 when the FIFO is empty.
- R8: `tx_data` shows the transmit FIFO head in write order. `tx_pop` is high exactly when the FIFO is not empty and `tx_idle` is high, and the head leaves the FIFO on that clock edge.
- R9: Reads on the data port leave the transmit FIFO unchanged, and writes on the data port leave the receive FIFO unchanged. With the access bit at 0, offset 0x04 reads as 0x00 and ignores writes.
- R10: Both FIFOs hold 16 entries. A read from an empty receive FIFO returns 0x00 and does not underflow. A push into a full FIFO is dropped, and `rx_full` reports when the receive FIFO is full.
- R11: A receive push and a data-port read in the same cycle both take effect. The read returns the old head and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_data | input | 8 | Received character, bit 0 first on the line |
| rx_perr | input | 1 | Parity error for this character |
| rx_ferr | input | 1 | Framing error for this character |
| rx_brk | input | 1 | Break condition for this character |
| rx_full | output | 1 | Receive FIFO full |
| tx_idle | input | 1 | Transmit shifter can take a byte |
| tx_pop | output | 1 | Head byte is taken this cycle |
| tx_data | output | 8 | Transmit FIFO head |
| baud_tick | output | 1 | 16x oversampling tick |

## Verification
Two events can land in the same cycle: a character arriving from the receive shifter and a software read that removes the receive head. The bench drives `rx_push` and a data-port read in one cycle while one byte is already queued. It checks that the read returns the older byte, that the line status then describes the newly pushed byte, and that a second read returns that byte. Transmit writes that meet shifter pops are also exercised: bytes are written while `tx_idle` is high, and the scoreboard judges the order in which they leave.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_push,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  output logic              rx_full,
  input  logic              tx_idle,
  output logic              tx_pop,
  output logic [7:0]        tx_data,
  output logic              baud_tick
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] CNT_FULL = (PTR_W+1)'(DEPTH);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_HI   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_LCR  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] OFS_LSR  = ADDR_W'(20);

  logic [7:0] lcr, div_lo, div_hi;
  wire dlab    = lcr[7];
  wire at_data = bus_addr == OFS_DATA;
  wire at_hi   = bus_addr == OFS_HI;

  wire rbr_rd = bus_rd && at_data && !dlab;
  wire thr_wr = bus_wr && at_data && !dlab;
  wire lo_wr  = bus_wr && at_data && dlab;
  wire hi_wr  = bus_wr && at_hi && dlab;
  wire div_wr = lo_wr || hi_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcr <= '0; div_lo <= '0; div_hi <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_LCR) lcr <= bus_wdata;
      if (lo_wr) div_lo <= bus_wdata;
      if (hi_wr) div_hi <= bus_wdata;
    end

  // receive FIFO: {brk, ferr, perr, data}
  logic [10:0]    rx_mem [DEPTH];
  logic [PTR_W:0] rx_wp, rx_rp;
  wire [PTR_W:0]  rx_cnt   = rx_wp - rx_rp;
  wire            rx_empty = rx_cnt == '0;
  assign rx_full = rx_cnt == CNT_FULL;
  wire rx_wen = rx_push && !rx_full;
  wire rx_ren = rbr_rd && !rx_empty;
  wire [7:0]  wl_mask = 8'hFF >> (2'd3 - lcr[1:0]);
  wire [10:0] rx_head = rx_empty ? 11'd0 : rx_mem[rx_rp[PTR_W-1:0]];

  always_ff @(posedge clk) if (rx_wen)
    rx_mem[rx_wp[PTR_W-1:0]] <= {rx_brk, rx_ferr, rx_perr, rx_data & wl_mask};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (rx_wen) rx_wp <= rx_wp + 1'b1;
      if (rx_ren) rx_rp <= rx_rp + 1'b1;
    end

  // transmit FIFO
  logic [7:0]     tx_mem [DEPTH];
  logic [PTR_W:0] tx_wp, tx_rp;
  wire [PTR_W:0]  tx_cnt   = tx_wp - tx_rp;
  wire            tx_empty = tx_cnt == '0;
  wire            tx_full  = tx_cnt == CNT_FULL;
  wire            tx_wen   = thr_wr && !tx_full;
  assign tx_pop  = tx_idle && !tx_empty;
  assign tx_data = tx_mem[tx_rp[PTR_W-1:0]];

  always_ff @(posedge clk) if (tx_wen) tx_mem[tx_wp[PTR_W-1:0]] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0;
    end else begin
      if (tx_wen) tx_wp <= tx_wp + 1'b1;
      if (tx_pop) tx_rp <= tx_rp + 1'b1;
    end

  // read mux
  wire [7:0] lsr = {2'b00, tx_empty, rx_head[10:8], 1'b0, !rx_empty};
  always_comb begin
    bus_rdata = '0;
    if (bus_rd)
      unique case (bus_addr)
        OFS_DATA: bus_rdata = dlab ? div_lo : rx_head[7:0];
        OFS_HI:   bus_rdata = dlab ? div_hi : 8'h00;
        OFS_LCR:  bus_rdata = lcr;
        OFS_LSR:  bus_rdata = lsr;
        default:  bus_rdata = '0;
      endcase
  end

  // baud tick generator
  wire [15:0] div_raw = {div_hi, div_lo};
  wire [15:0] div_eff = (div_raw == 16'd0) ? 16'd1 : div_raw;
  logic [15:0] tick_cnt;
  assign baud_tick = tick_cnt >= div_eff - 16'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  tick_cnt <= '0;
    else if (div_wr || baud_tick) tick_cnt <= '0;
    else                         tick_cnt <= tick_cnt + 16'd1;

  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && div_eff != 16'd1 && !div_wr) |=> !baud_tick);
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> tick_cnt == 16'd0);
  p_rx_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rbr_rd) |=> rx_cnt == CNT_FULL);
  p_tx_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && tx_full && !tx_pop) |=> tx_cnt == CNT_FULL);
  p_empty_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && rx_empty) |-> bus_rdata == 8'h00);
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> tx_rp == $past(tx_rp));
  p_div_no_fifo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (rx_wp == $past(rx_wp) || $past(rx_push)) && tx_wp == $past(tx_wp));
endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, rx_full;
  logic [7:0] rx_data = '0;
  logic tx_idle = 0, tx_pop, baud_tick;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  uart_regbank u_dut (.*);

  int nvec = 0, nerr = 0, tx_seen = 0;
  logic [10:0] rxq[$];
  logic [7:0]  txq[$];
  logic [1:0]  wl = 2'd0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  // transmit monitor: compare each byte the shifter takes against the scoreboard
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && tx_pop) begin
      tx_seen++;
      if (txq.size() == 0) chk(0, "R8 unexpected pop", tx_data, 0);
      else begin
        logic [7:0] e;
        e = txq.pop_front();
        chk(tx_data == e, "R8 tx order", tx_data, e);
      end
    end
  end

  task automatic bw(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic br(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic thr(input logic [7:0] d);
    if (txq.size() < 16) txq.push_back(d);
    bw(5'h00, d);
  endtask

  task automatic rxin(input logic [7:0] d, input logic p, f, b);
    @(negedge clk);
    rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b; rx_push = 1;
    if (rxq.size() < 16) rxq.push_back({b, f, p, d & (8'hFF >> (2'd3 - wl))});
    @(negedge clk); rx_push = 0;
  endtask

  task automatic rd_rbr(input string tag);
    logic [7:0] s, d;
    logic [10:0] e;
    e = (rxq.size() != 0) ? rxq[0] : 11'd0;
    br(5'h14, s);
    chk(s[0] == (rxq.size() != 0), {tag, " R7 data-ready"}, s[0], rxq.size() != 0);
    chk(s[4:2] == e[10:8], {tag, " R7 head flags"}, s[4:2], e[10:8]);
    br(5'h00, d);
    if (rxq.size() != 0) void'(rxq.pop_front());
    chk(d == e[7:0], {tag, " R1 data"}, d, e[7:0]);
  endtask

  task automatic tick_wait(output int n);
    n = 1;
    #1;
    while (!baud_tick && n < 1000) begin @(negedge clk); #1; n++; end
  endtask

  task automatic tick_gap(output int n);
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!baud_tick && n < 1000);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    br(5'h14, v); chk(v == 8'h20, "R7 reset status", v, 8'h20);
    br(5'h0C, v); chk(v == 8'h00, "R3 reset control", v, 8'h00);
    chk(!tx_pop && !rx_full, "R10 reset flags", {tx_pop, rx_full}, 0);

    // R3 / R1 / R7: 8-bit characters with assorted flags
    bw(5'h0C, 8'h03); wl = 2'd3;
    br(5'h0C, v); chk(v == 8'h03, "R3 control readback", v, 8'h03);
    rxin(8'hA5, 0, 0, 0); rxin(8'h3C, 1, 0, 0); rxin(8'hF0, 0, 1, 1); rxin(8'h81, 0, 0, 1);
    repeat (4) rd_rbr("rx8");
    rd_rbr("empty");

    // R6: 5-bit and 7-bit words
    bw(5'h0C, 8'h00); wl = 2'd0;
    rxin(8'hFF, 0, 0, 0);
    bw(5'h0C, 8'h02); wl = 2'd2;
    rxin(8'hFF, 1, 1, 0);
    rd_rbr("R6 w5"); rd_rbr("R6 w7");

    // R2 / R4 / R5: divisor banked behind the access bit
    bw(5'h0C, 8'h83);
    bw(5'h04, 8'h00); bw(5'h00, 8'h05);
    tick_wait(n); chk(n == 5, "R5 first tick after write", n, 5);
    tick_gap(n);  chk(n == 5, "R4 tick period 5", n, 5);
    br(5'h00, v); chk(v == 8'h05, "R2 low divisor readback", v, 8'h05);
    br(5'h04, v); chk(v == 8'h00, "R2 high divisor readback", v, 8'h00);
    bw(5'h00, 8'h00);
    tick_wait(n); chk(n == 1, "R4 zero divisor first tick", n, 1);
    tick_gap(n);  chk(n == 1, "R4 zero divisor period", n, 1);
    bw(5'h04, 8'h01);
    tick_wait(n); chk(n == 256, "R5 divisor 256 first tick", n, 256);
    tick_gap(n);  chk(n == 256, "R4 divisor 256 period", n, 256);
    bw(5'h0C, 8'h03); wl = 2'd3;
    br(5'h14, v); chk(v == 8'h20, "R2 fifos untouched by divisor access", v, 8'h20);

    // R8 / R9: transmit held while the shifter is busy
    thr(8'h11); thr(8'h22); thr(8'h33);
    chk(!tx_pop && tx_data == 8'h11, "R8 held while busy", {tx_pop, tx_data}, 8'h11);
    br(5'h14, v); chk(v == 8'h00, "R7 transmit not empty", v, 8'h00);
    br(5'h00, v); chk(v == 8'h00, "R9 read of data port with empty rx", v, 0);
    chk(tx_data == 8'h11, "R9 read leaves transmit FIFO", tx_data, 8'h11);
    br(5'h04, v); chk(v == 8'h00, "R9 offset 4 reads zero", v, 0);
    bw(5'h04, 8'h7E);
    br(5'h14, v); chk(v[0] == 1'b0, "R9 write leaves receive FIFO", v[0], 0);
    @(negedge clk); tx_idle = 1;
    repeat (10) @(negedge clk);
    chk(tx_seen == 3 && txq.size() == 0, "R8 drained", tx_seen, 3);
    br(5'h14, v); chk(v == 8'h20, "R7 transmit empty after drain", v, 8'h20);
    thr(8'h44); thr(8'h55);
    repeat (4) @(negedge clk);
    chk(tx_seen == 5, "R8 writes while idle", tx_seen, 5);

    // R10: full transmit FIFO drops extra writes
    @(negedge clk); tx_idle = 0;
    for (int i = 0; i < 18; i++) thr(8'(8'hA0 + i));
    chk(txq.size() == 16, "R10 model depth", txq.size(), 16);
    @(negedge clk); tx_idle = 1;
    repeat (24) @(negedge clk);
    chk(tx_seen == 21, "R10 transmit drop", tx_seen, 21);
    @(negedge clk); tx_idle = 0;

    // R10: full receive FIFO
    for (int i = 0; i < 17; i++) rxin(8'(8'h40 + i), i[0], 0, 0);
    chk(rx_full == 1'b1, "R10 rx_full", rx_full, 1);
    for (int i = 0; i < 16; i++) rd_rbr("R10 full drain");
    rd_rbr("R10 underflow");
    rxin(8'h5A, 0, 0, 0);
    rd_rbr("R10 after underflow");

    // R11: push and pop in the same cycle
    rxin(8'hC3, 1, 0, 0);
    @(negedge clk);
    bus_addr = 5'h00; bus_rd = 1;
    rx_data = 8'h3D; rx_perr = 0; rx_ferr = 1; rx_brk = 0; rx_push = 1;
    #1 v = bus_rdata;
    chk(v == 8'hC3, "R11 read returns old head", v, 8'hC3);
    void'(rxq.pop_front());
    rxq.push_back({1'b0, 1'b1, 1'b0, 8'h3D});
    @(negedge clk); bus_rd = 0; rx_push = 0;
    rd_rbr("R11 new byte kept");
    br(5'h14, v); chk(v[0] == 1'b0, "R11 empty after", v[0], 0);

    summary();
  end
endmodule